// File: doc/BRIEF.md
# Two-Stage Serial Bit-Clock Divider

This block derives the bit clock of a synchronous serial port from the parent clock. A 16-bit clock-select word sets the ratio. A 5-bit prescaler field sets a count of 1 to 32. A 3-bit divider code picks a power of two from 2 to 32, or passes the prescaled clock straight through. The resulting bit period is the product of the two, from 1 to 1024 parent cycles. The same encoding serves a transmit channel and a receive channel, so one instance is placed per channel.

Shift logic uses the serial clock output together with two single-cycle strobes. The strobes mark the cycles in which the serial clock has just gone high or just gone low. The idle level of the serial clock comes from a polarity input. When the enable is low the clock sits at that idle level and the counting restarts from the beginning. A new clock-select value is taken up only while the block is stopped, or at the boundary between two bit periods. When the ratio is exactly 1, the serial clock is the parent clock passed through a gate, and both strobes stay high in every running cycle. All pins are plain level signals: no data stream crosses the block, so there is no valid/ready handshake and no back-pressure.

Top module: `sclk_gen`

## Requirements
- R1: While reset is asserted, `sclk` equals `idle_pol` and both strobes are low.
- R2: The prescale ratio P is `csel[12:8]` plus one. The divider code in `csel[2:0]` gives D = 2, 4, 8, 16 or 32 for codes 0 to 4 and D = 1 for code 7. The bit period is N = P*D parent cycles.
- R3: Divider codes 5 and 6 behave exactly like code 7 (D = 1).
- R4: Each bit period begins with ceil(N/2) cycles at the idle level, followed by floor(N/2) cycles at the active level; odd N is allowed. The first period begins in the first cycle after `enable` is sampled high.
- R5: While `enable` is low, `sclk` sits at the idle level. After `enable` returns high, counting restarts at the beginning of a period, as in R4. Dropping `enable` while the clock is active produces one trailing edge, with its strobe.
- R6: When N = 1 and the block is running, the high phase of `clk` drives `sclk` to the non-idle level and the low phase drives it to the idle level. Both strobes are high in every running cycle.
- R7: When N > 1, `rise_stb` is high exactly in the cycles in which `sclk` has just changed from 0 to 1, and `fall_stb` exactly in those in which it has just changed from 1 to 0.
- R8: With `idle_pol` = 1 the serial clock idles high and its active phase is low. `idle_pol` is changed only while `enable` is low.
- R9: A new `csel` value takes effect only at the start of a period or while stopped, never inside a running period. Bits 15:13 and 7:3 of `csel` have no effect.
- R10: The largest setting (P = 32, code 4) gives a bit period of 1024 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the serial clock when high |
| idle_pol | input | 1 | Idle level of the serial clock |
| csel | input | 16 | Clock-select word (prescale and divider fields) |
| sclk | output | 1 | Serial bit clock |
| rise_stb | output | 1 | One-cycle strobe after a low-to-high change of `sclk` |
| fall_stb | output | 1 | One-cycle strobe after a high-to-low change of `sclk` |

## Verification
Every divider code is run against several prescale values. Even products such as 2, 12 and 16 show that the two stages multiply, and do not add. An odd product of 5 exposes any rounding error in the split between idle and active phases. Reserved codes 5 and 6 are set with prescale values above one to show they fall to the pass-through ratio, and with a prescale of one to reach the gated mode. Other runs change `csel` in the middle of a period, set unused bits to one, and drop the enable while the clock is active; these separate correct and incorrect update timing. A run at ratio 1024 checks the widest counters, and a run with idle-high polarity checks that the strobes swap with the level.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;

  // Clock-select word layout: the field positions are decoded by this block
  localparam int PRE_W    = 5;   // prescale field width (ratio minus one)
  localparam int PRE_LSB  = 8;
  localparam int CODE_W   = 3;   // divider code width
  localparam int CODE_LSB = 0;
  localparam int DLOG_MAX = 5;   // largest power-of-two stage is 2**DLOG_MAX
  localparam int DLOG_W   = $clog2(DLOG_MAX + 1);
  localparam int DC_W     = DLOG_MAX;  // divider stage counter width

  typedef struct packed {
    logic [PRE_W-1:0]  pre_m1;
    logic [CODE_W-1:0] code;
  } sclk_cfg_t;

  // Codes below DLOG_MAX select 2**(code+1); every other code passes through
  function automatic logic [DLOG_W-1:0] code_to_log2(input logic [CODE_W-1:0] code);
    if (code < CODE_W'(DLOG_MAX)) return DLOG_W'(code) + 1'b1;
    else                          return '0;
  endfunction

endpackage

// File: rtl/sclk_prescale.sv
module sclk_prescale #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] pre_m1,
  output logic [W-1:0] pc_q,
  output logic [W-1:0] pc_d,
  output logic         tick
);

  always_comb begin
    tick = (pc_q == pre_m1);
    if (clr)       pc_d = '0;
    else if (tick) pc_d = '0;
    else           pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

endmodule

// File: rtl/sclk_divstage.sv
module sclk_divstage #(
  parameter int CW = 5,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [LW-1:0] dlog,
  output logic [CW-1:0] dc_q,
  output logic [CW-1:0] dc_d,
  output logic          last
);

  logic [CW:0] span;

  always_comb begin
    span = {{CW{1'b0}}, 1'b1} << dlog;
    last = ({1'b0, dc_q} == (span - 1'b1));
    if (clr)       dc_d = '0;
    else if (tick) dc_d = last ? '0 : dc_q + 1'b1;
    else           dc_d = dc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dc_q <= '0;
    else        dc_q <= dc_d;
  end

endmodule

// File: rtl/sclk_edge.sv
module sclk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic act_d,
  input  logic run_q,
  input  logic byp,
  input  logic idle_pol,
  output logic act_q,
  output logic sclk,
  output logic rise_stb,
  output logic fall_stb
);

  logic lead, trail;
  logic rise_q, fall_q;

  always_comb begin
    lead  = act_d & ~act_q;
    trail = ~act_d & act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      rise_q <= idle_pol ? trail : lead;
      fall_q <= idle_pol ? lead : trail;
    end
  end

  // Ratio one: the parent clock itself is gated onto the output
  always_comb begin
    sclk     = byp ? ((clk & run_q) ^ idle_pol) : (act_q ^ idle_pol);
    rise_stb = byp ? run_q : rise_q;
    fall_stb = byp ? run_q : fall_q;
  end

endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
  import sclk_gen_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             idle_pol,
  input  logic [REG_W-1:0] csel,
  output logic             sclk,
  output logic             rise_stb,
  output logic             fall_stb
);

  sclk_cfg_t          cfg_q, cfg_in;
  logic               run_q, adv, clr, wrap, load, byp, no_div, act_d, act_q;
  logic               tick, last;
  logic [PRE_W-1:0]   pc_q, pc_d;
  logic [DC_W-1:0]    dc_q, dc_d;
  logic [DLOG_W-1:0]  dlog;
  logic [PRE_W:0]     pre_ratio, pre_half;
  logic [DC_W:0]      dc_half;

  always_comb begin
    cfg_in.pre_m1 = csel[PRE_LSB +: PRE_W];
    cfg_in.code   = csel[CODE_LSB +: CODE_W];
    dlog      = code_to_log2(cfg_q.code);
    no_div    = (dlog == '0);
    byp       = no_div && (cfg_q.pre_m1 == '0);
    adv       = enable & run_q;
    clr       = ~adv;
    wrap      = adv & tick & last;
    load      = ~enable | ~run_q | wrap;
    // Idle phase is the rounded-up half of the period
    pre_ratio = {1'b0, cfg_q.pre_m1} + 1'b1;
    pre_half  = pre_ratio - (pre_ratio >> 1);
    dc_half   = ({{DC_W{1'b0}}, 1'b1} << dlog) >> 1;
    act_d     = enable & (no_div ? ({1'b0, pc_d} >= pre_half)
                                 : ({1'b0, dc_d} >= dc_half));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cfg_q <= '0;
    end else begin
      run_q <= enable;
      if (load) cfg_q <= cfg_in;
    end
  end

  sclk_prescale #(.W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(clr), .pre_m1(cfg_q.pre_m1),
    .pc_q(pc_q), .pc_d(pc_d), .tick(tick)
  );

  sclk_divstage #(.CW(DC_W), .LW(DLOG_W)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .dlog(dlog),
    .dc_q(dc_q), .dc_d(dc_d), .last(last)
  );

  sclk_edge u_edge (
    .clk(clk), .rst_n(rst_n), .act_d(act_d), .run_q(run_q), .byp(byp),
    .idle_pol(idle_pol), .act_q(act_q), .sclk(sclk),
    .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

endmodule

// File: rtl/sclk_gen_chk.sv
module sclk_gen_chk
  import sclk_gen_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      enable,
  input logic      idle_pol,
  input logic      run_q,
  input logic      act_q,
  input logic      byp,
  input logic      wrap,
  input logic      rise_stb,
  input logic      fall_stb,
  input sclk_cfg_t cfg_q
);

  // R4: a period starts idle when the clock is first enabled
  a_r4_first_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> !act_q);

  // R5: the active phase never survives a disabled cycle
  a_r5_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !act_q);

  // R6: the divided path stays quiet in pass-through mode
  a_r6_byp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    byp |-> !act_q);

  // R7: never both strobes in divided mode
  a_r7_one_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !byp |-> $onehot0({rise_stb, fall_stb}));

  // R7: the leading edge carries the strobe matching the polarity
  a_r7_lead_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> ($past(idle_pol) ? fall_stb : rise_stb));

  // R9: settings hold inside a running period
  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && enable && !wrap) |=> $stable(cfg_q));

endmodule

bind sclk_gen sclk_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .idle_pol(idle_pol),
  .run_q(run_q), .act_q(act_q), .byp(byp), .wrap(wrap),
  .rise_stb(rise_stb), .fall_stb(fall_stb), .cfg_q(cfg_q)
);

// File: tb/sclk_gen_bench.sv
module sclk_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        idle_pol = 1'b0;
  logic [15:0] csel = 16'h0000;
  logic        sclk, rise_stb, fall_stb;

  int    n_chk = 0;
  int    n_err = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // Reference model state
  int m_P = 1, m_D = 2, m_pos = 0, m_N;
  bit m_run = 0, m_act = 0, m_rise = 0, m_fall = 0, m_prev, m_byp;

  always #10 clk = ~clk;

  sclk_gen u_sclk_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .idle_pol(idle_pol),
    .csel(csel), .sclk(sclk), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  task automatic chk(string req, string what, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s at cycle %0d: actual=%0b expected=%0b", req, what, cyc, got, exp);
    end
  endtask

  task automatic load_cfg();
    int code;
    m_P  = int'(csel[12:8]) + 1;
    code = int'(csel[2:0]);
    m_D  = (code < 5) ? (2 << code) : 1;
  endtask

  always @(posedge clk) begin
    string ts, tb;
    cyc++;
    if (!rst_n) begin
      m_run = 0; m_pos = 0; m_act = 0; m_P = 1; m_D = 2; m_rise = 0; m_fall = 0;
    end else begin
      m_prev = m_act;
      if (!enable) begin
        m_run = 0; m_pos = 0; load_cfg();
      end else if (!m_run) begin
        m_run = 1; m_pos = 0; load_cfg();
      end else if (m_pos == m_P * m_D - 1) begin
        m_pos = 0; load_cfg();
      end else begin
        m_pos++;
      end
      m_N    = m_P * m_D;
      m_act  = enable && (m_pos >= m_N - m_N / 2);
      m_rise = idle_pol ? (!m_act && m_prev) : (m_act && !m_prev);
      m_fall = idle_pol ? (m_act && !m_prev) : (!m_act && m_prev);
    end
    m_byp = rst_n && (m_P * m_D == 1);
    ts = !rst_n ? "R1" : (m_byp ? "R6" : cur_req);
    tb = !rst_n ? "R1" : (m_byp ? "R6" : "R7");
    #5;  // clk high
    chk(ts, "sclk(high phase)", sclk, m_byp ? (m_run ^ idle_pol) : (m_act ^ idle_pol));
    chk(tb, "rise_stb", rise_stb, m_byp ? m_run : m_rise);
    chk(tb, "fall_stb", fall_stb, m_byp ? m_run : m_fall);
    #10; // clk low
    chk(ts, "sclk(low phase)", sclk, m_byp ? idle_pol : (m_act ^ idle_pol));
  end

  task automatic run_cfg(string req, logic [15:0] c, logic pol, int cycles);
    @(negedge clk);
    enable = 1'b0; cur_req = req; csel = c; idle_pol = pol;
    @(negedge clk);
    enable = 1'b1;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    run_cfg("R2", 16'h0000, 1'b0, 12);    // 1 x /2
    run_cfg("R2", 16'h0201, 1'b0, 40);    // 3 x /4
    run_cfg("R2", 16'h0102, 1'b0, 50);    // 2 x /8
    run_cfg("R4", 16'h0407, 1'b0, 30);    // 5 x /1, odd period
    run_cfg("R3", 16'h0305, 1'b0, 20);    // reserved code 5
    run_cfg("R3", 16'h0206, 1'b1, 20);    // reserved code 6
    run_cfg("R6", 16'h0007, 1'b0, 10);    // gated pass-through
    run_cfg("R6", 16'h0005, 1'b1, 10);    // pass-through via reserved code
    run_cfg("R8", 16'h0103, 1'b1, 80);    // idle-high polarity
    run_cfg("R9", 16'hE1F8, 1'b0, 21);    // unused bits set, 2 x /2
    csel = 16'h0002;                      // mid-period change
    repeat (30) @(negedge clk);
    csel = 16'h0007;                      // into pass-through at boundary
    repeat (10) @(negedge clk);
    csel = 16'h0300;                      // back to divided
    repeat (20) @(negedge clk);
    run_cfg("R5", 16'h0003, 1'b0, 12);    // /16, drop while active
    enable = 1'b0;
    repeat (3) @(negedge clk);
    enable = 1'b1;
    repeat (40) @(negedge clk);
    run_cfg("R10", 16'h1F04, 1'b0, 2100); // 32 x /32
    enable = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end

  always @(posedge clk) begin
    if (cyc > 100000 && !done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      finish_run();
    end
  end

endmodule